// File: doc/BRIEF.md
# Display Control Register Block

This block is the write side of a graphics unit's display-control port, together with the packed status word that reports the display setup. Software or a bus bridge writes 32-bit control words. The top byte of each word selects an operation, and the lower bits carry that operation's arguments. The operations update the display configuration: blanking, the interrupt flag, the transfer direction, the framebuffer origin, the horizontal and vertical visible windows and the display mode.

Most of the configuration is visible as bits in one 32-bit status word. That word is built combinationally from the registers, so it can be read in any cycle. The framebuffer origin and the two display windows have no status bits and are driven as separate output buses for the video timing logic. One operation does not touch any register here. It sends a one-cycle pulse that tells the neighbouring command packet sequencer to drop any half-collected packet and go back to waiting for a fresh command word.

A display-mode write with bit 7 set asks for a mode this block does not support. That write is dropped, and a sticky error bit is raised in the status word.

Top module: `disp_ctl_regs`

## Requirements
- R1: After rst_n is held low, status_word reads 0x00C00000 when tex_disable is 0: bit 23 (display off) and bit 22 (interlace) are 1 and every other bit is 0. All range and origin outputs read zero, and cmdbuf_reset_pulse is 0.
- R2: A write with opcode 0x00 (bits 31:24) returns every register to the R1 values, including the sticky error bit. It overrides an irq_raise in the same cycle.
- R3: A write with opcode 0x01 sets cmdbuf_reset_pulse to 1 for exactly the cycle after the write and changes no register. The pulse is 0 after any other write or idle cycle.
- R4: The interrupt flag is status bit 24. irq_raise sets it. A write with opcode 0x02 clears it. When both happen in the same cycle, the flag is set.
- R5: A write with opcode 0x03 copies data bit 0 into the display-off flag, status bit 23.
- R6: A write with opcode 0x04 copies data bits 1:0 into the transfer direction, status bits 30:29.
- R7: A write with opcode 0x05 loads vram_base_x from data bits 9:0 and vram_base_y from data bits 18:10.
- R8: A write with opcode 0x06 loads h_start from bits 11:0 and h_end from bits 23:12. A write with opcode 0x07 loads v_start from bits 9:0 and v_end from bits 19:10.
- R9: A write with opcode 0x08 and bit 7 clear updates the mode. Data bits 1:0 go to status 18:17, bit 6 to status 16, bit 2 (vertical resolution) to status 19, bit 3 (video standard) to status 20, bit 4 (24-bit colour) to status 21 and bit 5 (interlace) to status 22.
- R10: A write with opcode 0x08 and bit 7 set leaves the mode unchanged and sets status bit 31. Bit 31 stays set until a reset or an opcode 0x00 write.
- R11: Writes with an opcode above 0x08, and cycles with ctl_wr_en low, change no register.
- R12: status bit 15 follows the tex_disable input in the same cycle. Status bits 14:0 and 28:25 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_wr_data | input | 32 | Control word, opcode in bits 31:24 |
| irq_raise | input | 1 | Sets the interrupt flag |
| tex_disable | input | 1 | Texture-disable state from drawing setup |
| status_word | output | 32 | Packed status |
| cmdbuf_reset_pulse | output | 1 | One-cycle request to clear the command packet buffer |
| vram_base_x | output | 10 | Display framebuffer origin, X |
| vram_base_y | output | 9 | Display framebuffer origin, Y |
| h_start | output | 12 | Horizontal display start |
| h_end | output | 12 | Horizontal display end |
| v_start | output | 10 | Vertical display start |
| v_end | output | 10 | Vertical display end |

## Verification
The bench builds the block with its default widths: 12-bit horizontal fields, 10-bit vertical fields and a 10/9-bit framebuffer origin. Those widths put every argument bit of the range and origin writes in play, up to bit 23, so random data exercises both field boundaries of each packed write, including the all-ones case. The random opcode mix includes rare soft resets and unknown opcodes, so the sticky error bit and the irq priority get hit many times from different register states.

// File: rtl/disp_ctl_pkg.sv
// Shared opcode encoding and mode-register layout for the display control block.
// Assumes the opcode always sits in the top byte of a 32-bit control word.
package disp_ctl_pkg;

    typedef enum logic [7:0] {
        OP_SOFT_RESET = 8'h00,
        OP_CMDBUF_CLR = 8'h01,
        OP_IRQ_ACK    = 8'h02,
        OP_DISP_EN    = 8'h03,
        OP_DMA_DIR    = 8'h04,
        OP_VRAM_BASE  = 8'h05,
        OP_HRANGE     = 8'h06,
        OP_VRANGE     = 8'h07,
        OP_MODE       = 8'h08
    } ctl_op_e;

    typedef struct packed {
        logic [1:0] hres_lo;
        logic       hres_hi;
        logic       vres;
        logic       std_sel;
        logic       depth24;
        logic       interlace;
    } mode_t;

    localparam mode_t MODE_DEFAULT = '{hres_lo: 2'b00, hres_hi: 1'b0, vres: 1'b0,
                                       std_sel: 1'b0, depth24: 1'b0, interlace: 1'b1};

endpackage

// File: rtl/disp_ctl_decode.sv
// Opcode decoder: turns a qualified control write into one strobe per operation.
// Assumes the caller supplies the opcode byte and the unsupported-mode bit (data bit 7).
module disp_ctl_decode
    import disp_ctl_pkg::*;
(
    input  logic       wr_en,
    input  logic [7:0] opcode,
    input  logic       mode_bad_bit,
    output logic       s_soft_rst,
    output logic       s_cmdbuf,
    output logic       s_irq_ack,
    output logic       s_disp_en,
    output logic       s_dma,
    output logic       s_vram,
    output logic       s_hrange,
    output logic       s_vrange,
    output logic       s_mode_ok,
    output logic       s_mode_bad
);

    // Decode the opcode into independent strobes; unknown opcodes raise nothing.
    always_comb begin
        s_soft_rst = 1'b0;
        s_cmdbuf   = 1'b0;
        s_irq_ack  = 1'b0;
        s_disp_en  = 1'b0;
        s_dma      = 1'b0;
        s_vram     = 1'b0;
        s_hrange   = 1'b0;
        s_vrange   = 1'b0;
        s_mode_ok  = 1'b0;
        s_mode_bad = 1'b0;
        if (wr_en) begin
            case (opcode)
                OP_SOFT_RESET: s_soft_rst = 1'b1;
                OP_CMDBUF_CLR: s_cmdbuf   = 1'b1;
                OP_IRQ_ACK:    s_irq_ack  = 1'b1;
                OP_DISP_EN:    s_disp_en  = 1'b1;
                OP_DMA_DIR:    s_dma      = 1'b1;
                OP_VRAM_BASE:  s_vram     = 1'b1;
                OP_HRANGE:     s_hrange   = 1'b1;
                OP_VRANGE:     s_vrange   = 1'b1;
                OP_MODE: begin
                    s_mode_ok  = !mode_bad_bit;
                    s_mode_bad = mode_bad_bit;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/disp_ctl_mode_reg.sv
// Display mode register plus the sticky unsupported-mode error flag.
// Assumes the strobes are mutually exclusive; a soft reset restores the defaults.
module disp_ctl_mode_reg
    import disp_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       mode_ok,
    input  logic       mode_bad,
    input  logic [6:0] mode_data,
    output mode_t      mode_q,
    output logic       err_q
);

    mode_t mode_d;

    // Map the write's argument bits onto the mode fields.
    always_comb begin
        mode_d.hres_lo   = mode_data[1:0];
        mode_d.vres      = mode_data[2];
        mode_d.std_sel   = mode_data[3];
        mode_d.depth24   = mode_data[4];
        mode_d.interlace = mode_data[5];
        mode_d.hres_hi   = mode_data[6];
    end

    // Hold the mode; load on a valid mode write, flag and drop an unsupported one.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            mode_q <= MODE_DEFAULT;
            err_q  <= 1'b0;
        end else begin
            if (mode_ok)  mode_q <= mode_d;
            if (mode_bad) err_q  <= 1'b1;
        end
    end

    p_bad_mode_dropped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bad |=> ($stable(mode_q) && err_q));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !soft_rst) |=> err_q);

    p_soft_reset_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mode_q == MODE_DEFAULT && !err_q));

endmodule

// File: rtl/disp_ctl_cfg_regs.sv
// Display configuration registers: blanking, interrupt flag, transfer direction,
// framebuffer origin and the two display windows.
// Assumes 2*H_W, 2*V_W and VX_W+VY_W each fit in the 24 argument bits.
module disp_ctl_cfg_regs #(
    parameter int H_W  = 12,
    parameter int V_W  = 10,
    parameter int VX_W = 10,
    parameter int VY_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            s_irq_ack,
    input  logic            s_disp_en,
    input  logic            s_dma,
    input  logic            s_vram,
    input  logic            s_hrange,
    input  logic            s_vrange,
    input  logic            irq_raise,
    input  logic [23:0]     arg,
    output logic            disp_off_q,
    output logic            irq_q,
    output logic [1:0]      dma_dir_q,
    output logic [VX_W-1:0] vx_q,
    output logic [VY_W-1:0] vy_q,
    output logic [H_W-1:0]  hs_q,
    output logic [H_W-1:0]  he_q,
    output logic [V_W-1:0]  vs_q,
    output logic [V_W-1:0]  ve_q
);

    // Soft reset beats everything; a raise beats an acknowledge in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            disp_off_q <= 1'b1;
            irq_q      <= 1'b0;
            dma_dir_q  <= '0;
            vx_q       <= '0;
            vy_q       <= '0;
            hs_q       <= '0;
            he_q       <= '0;
            vs_q       <= '0;
            ve_q       <= '0;
        end else begin
            if (irq_raise)      irq_q <= 1'b1;
            else if (s_irq_ack) irq_q <= 1'b0;
            if (s_disp_en) disp_off_q <= arg[0];
            if (s_dma)     dma_dir_q  <= arg[1:0];
            if (s_vram) begin
                vx_q <= arg[VX_W-1:0];
                vy_q <= arg[VX_W +: VY_W];
            end
            if (s_hrange) begin
                hs_q <= arg[H_W-1:0];
                he_q <= arg[H_W +: H_W];
            end
            if (s_vrange) begin
                vs_q <= arg[V_W-1:0];
                ve_q <= arg[V_W +: V_W];
            end
        end
    end

    p_irq_raise_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raise && !soft_rst) |=> irq_q);

    p_irq_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_irq_ack && !irq_raise) |=> !irq_q);

    p_soft_reset_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (disp_off_q && !irq_q && dma_dir_q == 2'b00 && hs_q == '0 && ve_q == '0));

endmodule

// File: rtl/disp_ctl_status_pack.sv
// Combinational assembly of the 32-bit status word from the register state.
// Assumes a fixed bit layout that software decodes; unused bits read zero.
module disp_ctl_status_pack
    import disp_ctl_pkg::*;
(
    input  logic        tex_disable,
    input  mode_t       mode,
    input  logic        err,
    input  logic        disp_off,
    input  logic        irq,
    input  logic [1:0]  dma_dir,
    output logic [31:0] status
);

    // Place each field at its fixed position.
    always_comb begin
        status        = '0;
        status[15]    = tex_disable;
        status[16]    = mode.hres_hi;
        status[18:17] = mode.hres_lo;
        status[19]    = mode.vres;
        status[20]    = mode.std_sel;
        status[21]    = mode.depth24;
        status[22]    = mode.interlace;
        status[23]    = disp_off;
        status[24]    = irq;
        status[30:29] = dma_dir;
        status[31]    = err;
    end

endmodule

// File: rtl/disp_ctl_regs.sv
// Top of the display control block: decodes control writes, holds the display
// configuration, packs the status word and issues the command-buffer clear pulse.
// Assumes one control write per cycle at most.
module disp_ctl_regs
    import disp_ctl_pkg::*;
#(
    parameter int H_W  = 12,
    parameter int V_W  = 10,
    parameter int VX_W = 10,
    parameter int VY_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr_en,
    input  logic [31:0]     ctl_wr_data,
    input  logic            irq_raise,
    input  logic            tex_disable,
    output logic [31:0]     status_word,
    output logic            cmdbuf_reset_pulse,
    output logic [VX_W-1:0] vram_base_x,
    output logic [VY_W-1:0] vram_base_y,
    output logic [H_W-1:0]  h_start,
    output logic [H_W-1:0]  h_end,
    output logic [V_W-1:0]  v_start,
    output logic [V_W-1:0]  v_end
);

    logic  s_soft_rst, s_cmdbuf, s_irq_ack, s_disp_en, s_dma;
    logic  s_vram, s_hrange, s_vrange, s_mode_ok, s_mode_bad;
    mode_t mode_q;
    logic  err_q, disp_off_q, irq_q;
    logic [1:0] dma_dir_q;

    disp_ctl_decode u_decode (
        .wr_en       (ctl_wr_en),
        .opcode      (ctl_wr_data[31:24]),
        .mode_bad_bit(ctl_wr_data[7]),
        .s_soft_rst  (s_soft_rst),
        .s_cmdbuf    (s_cmdbuf),
        .s_irq_ack   (s_irq_ack),
        .s_disp_en   (s_disp_en),
        .s_dma       (s_dma),
        .s_vram      (s_vram),
        .s_hrange    (s_hrange),
        .s_vrange    (s_vrange),
        .s_mode_ok   (s_mode_ok),
        .s_mode_bad  (s_mode_bad)
    );

    disp_ctl_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (s_soft_rst),
        .mode_ok  (s_mode_ok),
        .mode_bad (s_mode_bad),
        .mode_data(ctl_wr_data[6:0]),
        .mode_q   (mode_q),
        .err_q    (err_q)
    );

    disp_ctl_cfg_regs #(.H_W(H_W), .V_W(V_W), .VX_W(VX_W), .VY_W(VY_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (s_soft_rst),
        .s_irq_ack (s_irq_ack),
        .s_disp_en (s_disp_en),
        .s_dma     (s_dma),
        .s_vram    (s_vram),
        .s_hrange  (s_hrange),
        .s_vrange  (s_vrange),
        .irq_raise (irq_raise),
        .arg       (ctl_wr_data[23:0]),
        .disp_off_q(disp_off_q),
        .irq_q     (irq_q),
        .dma_dir_q (dma_dir_q),
        .vx_q      (vram_base_x),
        .vy_q      (vram_base_y),
        .hs_q      (h_start),
        .he_q      (h_end),
        .vs_q      (v_start),
        .ve_q      (v_end)
    );

    disp_ctl_status_pack u_status (
        .tex_disable(tex_disable),
        .mode       (mode_q),
        .err        (err_q),
        .disp_off   (disp_off_q),
        .irq        (irq_q),
        .dma_dir    (dma_dir_q),
        .status     (status_word)
    );

    // Register the command-buffer clear strobe into a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) cmdbuf_reset_pulse <= 1'b0;
        else        cmdbuf_reset_pulse <= s_cmdbuf;
    end

    p_pulse_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmdbuf_reset_pulse |-> $past(ctl_wr_en && ctl_wr_data[31:24] == 8'h01));

    p_unknown_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && ctl_wr_data[31:24] > 8'h08)
        |=> $stable({vram_base_x, vram_base_y, h_start, h_end, v_start, v_end, status_word[23:16]}));

endmodule

// File: tb/disp_ctl_regs_tb_top.sv
// Self-checking bench: seeded random control writes plus directed corners,
// compared against a register model kept in bench variables.
module disp_ctl_regs_tb_top;

    localparam int H_W = 12, V_W = 10, VX_W = 10, VY_W = 9;

    logic clk = 1'b0, rst_n = 1'b0, ctl_wr_en = 1'b0, irq_raise = 1'b0, tex_disable = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic [31:0] status_word;
    logic cmdbuf_reset_pulse;
    logic [VX_W-1:0] vram_base_x;
    logic [VY_W-1:0] vram_base_y;
    logic [H_W-1:0] h_start, h_end;
    logic [V_W-1:0] v_start, v_end;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // model state
    logic m_off, m_irq, m_err, m_pulse;
    logic [1:0] m_dma, m_hlo;
    logic m_hhi, m_vres, m_std, m_dep, m_il;
    logic [VX_W-1:0] m_vx;
    logic [VY_W-1:0] m_vy;
    logic [H_W-1:0] m_hs, m_he;
    logic [V_W-1:0] m_vs, m_ve;

    disp_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .irq_raise(irq_raise), .tex_disable(tex_disable), .status_word(status_word),
        .cmdbuf_reset_pulse(cmdbuf_reset_pulse), .vram_base_x(vram_base_x),
        .vram_base_y(vram_base_y), .h_start(h_start), .h_end(h_end),
        .v_start(v_start), .v_end(v_end)
    );

    always #5 clk = ~clk;

    task automatic model_reset();
        m_off = 1; m_irq = 0; m_err = 0; m_dma = 0; m_hlo = 0; m_hhi = 0;
        m_vres = 0; m_std = 0; m_dep = 0; m_il = 1;
        m_vx = 0; m_vy = 0; m_hs = 0; m_he = 0; m_vs = 0; m_ve = 0;
    endtask

    function automatic logic [31:0] exp_status(input logic tex);
        logic [31:0] s;
        s = '0;
        s[15] = tex; s[16] = m_hhi; s[18:17] = m_hlo; s[19] = m_vres; s[20] = m_std;
        s[21] = m_dep; s[22] = m_il; s[23] = m_off; s[24] = m_irq;
        s[30:29] = m_dma; s[31] = m_err;
        return s;
    endfunction

    function automatic string req_of(input logic en, input logic [31:0] d);
        if (!en) return "R11";
        case (d[31:24])
            8'h00: return "R2";
            8'h01: return "R3";
            8'h02: return "R4";
            8'h03: return "R5";
            8'h04: return "R6";
            8'h05: return "R7";
            8'h06, 8'h07: return "R8";
            8'h08: return d[7] ? "R10" : "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic model_write(input logic en, input logic [31:0] d, input logic irq);
        m_pulse = en && d[31:24] == 8'h01;
        if (en && d[31:24] == 8'h00) begin
            model_reset();
        end else begin
            if (irq) m_irq = 1;
            else if (en && d[31:24] == 8'h02) m_irq = 0;
            if (en) begin
                case (d[31:24])
                    8'h03: m_off = d[0];
                    8'h04: m_dma = d[1:0];
                    8'h05: begin m_vx = d[9:0]; m_vy = d[18:10]; end
                    8'h06: begin m_hs = d[11:0]; m_he = d[23:12]; end
                    8'h07: begin m_vs = d[9:0]; m_ve = d[19:10]; end
                    8'h08: if (d[7]) m_err = 1;
                           else begin
                               m_hlo = d[1:0]; m_vres = d[2]; m_std = d[3];
                               m_dep = d[4]; m_il = d[5]; m_hhi = d[6];
                           end
                    default: ;
                endcase
            end
        end
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "status", status_word, exp_status(tex_disable));
        chk(req, "pulse", 32'(cmdbuf_reset_pulse), 32'(m_pulse));
        chk(req, "vram_x", 32'(vram_base_x), 32'(m_vx));
        chk(req, "vram_y", 32'(vram_base_y), 32'(m_vy));
        chk(req, "h_start", 32'(h_start), 32'(m_hs));
        chk(req, "h_end", 32'(h_end), 32'(m_he));
        chk(req, "v_start", 32'(v_start), 32'(m_vs));
        chk(req, "v_end", 32'(v_end), 32'(m_ve));
    endtask

    // Drive one cycle at a falling edge, update the model, check at the next falling edge.
    task automatic apply(input logic en, input logic [31:0] d, input logic irq, input logic tex);
        ctl_wr_en = en; ctl_wr_data = d; irq_raise = irq; tex_disable = tex;
        model_write(en, d, irq);
        @(negedge clk);
        check_all(req_of(en, d));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5c_0a7e));
        m_pulse = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset status", status_word, 32'h00C0_0000);
        check_all("R1");
        // R12: texture-disable passes straight through
        tex_disable = 1; #1;
        chk("R12", "tex bit", status_word, 32'h00C0_8000);
        tex_disable = 0;
        @(negedge clk);
        // R9: mode fields, all set
        apply(1, 32'h0800_007F & 32'h0800_007F, 0, 0);
        chk("R9", "mode all", status_word & 32'h007F_0000, 32'h007F_0000);
        // R10: unsupported mode dropped, sticky error
        apply(1, 32'h0800_0080, 0, 0);
        chk("R10", "err set", status_word[31], 1'b1);
        apply(1, 32'h0800_0000, 0, 0);
        chk("R10", "err stays", status_word[31], 1'b1);
        // R11: unknown opcode and idle with all-ones data
        apply(1, 32'hFFFF_FFFF, 0, 0);
        apply(0, 32'h0500_FFFF, 0, 0);
        // R4: raise and ack in the same cycle leaves the flag set
        apply(1, 32'h0200_0000, 1, 0);
        chk("R4", "raise wins", status_word[24], 1'b1);
        apply(1, 32'h0200_0000, 0, 0);
        // R3: back-to-back clears then idle
        apply(1, 32'h0100_0000, 0, 0);
        apply(1, 32'h0100_0000, 0, 0);
        apply(0, 32'h0, 0, 0);
        chk("R3", "pulse gone", 32'(cmdbuf_reset_pulse), 32'h0);
        // R8: all-ones range boundaries
        apply(1, 32'h06FF_FFFF, 0, 0);
        apply(1, 32'h07FF_FFFF, 0, 0);
        // R2: soft reset clears error and overrides irq_raise
        apply(1, 32'h0000_0000, 1, 0);
        chk("R2", "soft reset", status_word, 32'h00C0_0000);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] op;
            logic [3:0] r;
            r = 4'($urandom % 16);
            if (r == 0) op = ($urandom % 4 == 0) ? 8'h00 : 8'h08;
            else if (r < 9) op = 8'(r);
            else if (r < 12) op = 8'h08;
            else op = 8'($urandom);
            apply(($urandom % 8) != 0, {op, 24'($urandom)}, ($urandom % 6) == 0, 1'($urandom));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule